// File: doc/BRIEF.md
# Cascaded Secondary Interrupt Controller

This block collects 32 level-sensitive interrupt lines and places them behind a primary vectored controller. Each line is sampled into a raw level register. An enable mask selects which lines take part in a single combined request, and that request is driven on output line 31, which feeds the primary controller's cascade input. Separately, any line in the range 21 to 30 can be routed straight to the output with the same index. That output follows the line's level whatever the enable mask holds, so the primary controller can see those sources individually.

Software reaches the block through a single-cycle register bus with a select strobe, a write flag, a 10-bit word address (a 4 KB window of 32-bit words) and a 32-bit data path. Enable bits change only through set and clear words, so software never needs a read-modify-write. Two extra words set or clear enable bit 0 alone. This gives a software-raised interrupt on line 0.

Top module: `casc_irq_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released before any write, the raw level, enable mask and pass-through enable all read zero and every output bit is low.
- R2: Word 1 reads the raw level. Its bit i equals input i as sampled at the most recent rising clock edge, so an input change shows up one edge later.
- R3: Output bit 31 is high exactly when the raw level ANDed with the enable mask is nonzero. Word 0 reads that AND.
- R4: A write to word 2 ORs the write data into the enable mask. A read of word 2 returns the enable mask.
- R5: A write to word 3 clears every enable bit that is 1 in the write data. Word 3 reads as zero.
- R6: Word 4 reads the raw level of line 0 in bit 0, with all other bits zero. A write of nonzero data to word 4 sets enable bit 0, and a write of nonzero data to word 5 clears it. A write of zero to either word changes nothing.
- R7: Word 8 reads the pass-through enable. A write to word 8 ORs in the write data ANDed with 0x7FE00000, so only bits 21 to 30 can ever be set. A write to word 9 clears the bits that are 1 in the write data.
- R8: For 21 ≤ i ≤ 30, output i equals raw level bit i while pass-through bit i is set, whatever the enable mask holds, and is low otherwise. Outputs 0 to 20 are always low.
- R9: Words 6, 7 and 10 to 1023 read as zero, and so do the write-only words 3, 5 and 9. Writes to words 0, 1, 6, 7 and 10 to 1023 change no register and no output.
- R10: A write takes effect at the rising edge where select and write are both high, and no output changes before that edge. Read data follows the address with no clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| irqIn | input | 32 | Level-sensitive interrupt lines |
| busSel | input | 1 | Register access strobe |
| busWr | input | 1 | Write when high, read when low |
| busAddr | input | 10 | Word address within the 4 KB window |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, combinational from busAddr |
| irqOut | output | 32 | Bit 31 is the cascade request; bits 21–30 are pass-through lines; bits 0–20 are tied low |

## Verification
The assertions take for granted that reset is released between clock edges. They also assume that the select, write, address and data inputs hold steady around each rising edge, because the write checks compare each register with the data sampled on the strobe edge. The bench drives every input on the falling edge and deasserts the select strobe right after each write edge, so it stays within those bounds. Random stimulus mixes zero and nonzero data across every defined word and several undefined ones, so that soft-bit writes of zero and ignored writes both occur often.

// File: rtl/casc_irq_pkg.sv
package casc_irq_pkg;

  // Word indices of the register window
  localparam int unsigned WORD_STATUS   = 0;
  localparam int unsigned WORD_RAW      = 1;
  localparam int unsigned WORD_MASK_SET = 2;
  localparam int unsigned WORD_MASK_CLR = 3;
  localparam int unsigned WORD_SOFT_SET = 4;
  localparam int unsigned WORD_SOFT_CLR = 5;
  localparam int unsigned WORD_PASS_SET = 8;
  localparam int unsigned WORD_PASS_CLR = 9;

  // Write strobes from the decoder to the datapath
  typedef struct packed {
    logic maskSet;
    logic maskClr;
    logic softSet;
    logic softClr;
    logic passSet;
    logic passClr;
  } wrStrobe_t;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_STATUS,
    RD_RAW,
    RD_MASK,
    RD_SOFT,
    RD_PASS
  } rdSel_t;

endpackage

// File: rtl/casc_irq_decode.sv
module casc_irq_decode
  import casc_irq_pkg::*;
#(
  parameter int unsigned WORD_AW = 10,
  parameter int unsigned DATA_W  = 32
) (
  input  logic               busSel,
  input  logic               busWr,
  input  logic [WORD_AW-1:0] busAddr,
  input  logic [DATA_W-1:0]  busWdata,
  output wrStrobe_t          strb,
  output rdSel_t             rdSel
);

  logic wrEn;
  logic dataNonZero;

  assign wrEn        = busSel & busWr;
  assign dataNonZero = |busWdata;

  always_comb begin
    strb = '0;
    if (wrEn) begin
      if (busAddr == WORD_AW'(WORD_MASK_SET)) strb.maskSet = 1'b1;
      if (busAddr == WORD_AW'(WORD_MASK_CLR)) strb.maskClr = 1'b1;
      if (busAddr == WORD_AW'(WORD_SOFT_SET)) strb.softSet = dataNonZero;
      if (busAddr == WORD_AW'(WORD_SOFT_CLR)) strb.softClr = dataNonZero;
      if (busAddr == WORD_AW'(WORD_PASS_SET)) strb.passSet = 1'b1;
      if (busAddr == WORD_AW'(WORD_PASS_CLR)) strb.passClr = 1'b1;
    end
  end

  always_comb begin
    rdSel = RD_NONE;
    if (busAddr == WORD_AW'(WORD_STATUS))   rdSel = RD_STATUS;
    if (busAddr == WORD_AW'(WORD_RAW))      rdSel = RD_RAW;
    if (busAddr == WORD_AW'(WORD_MASK_SET)) rdSel = RD_MASK;
    if (busAddr == WORD_AW'(WORD_SOFT_SET)) rdSel = RD_SOFT;
    if (busAddr == WORD_AW'(WORD_PASS_SET)) rdSel = RD_PASS;
  end

endmodule

// File: rtl/casc_irq_datapath.sv
module casc_irq_datapath
  import casc_irq_pkg::*;
#(
  parameter int unsigned LINES   = 32,
  parameter int unsigned PASS_LO = 21,
  parameter int unsigned PASS_HI = 30
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [LINES-1:0] irqIn,
  input  logic [LINES-1:0] wdata,
  input  wrStrobe_t        strb,
  input  rdSel_t           rdSel,
  output logic [LINES-1:0] rdata,
  output logic [LINES-1:0] irqOut
);

  localparam int unsigned CASC_IDX = LINES - 1;

  function automatic logic [LINES-1:0] passMaskCalc();
    logic [LINES-1:0] m;
    m = '0;
    for (int i = 0; i < int'(LINES); i++) begin
      if (i >= int'(PASS_LO) && i <= int'(PASS_HI)) m[i] = 1'b1;
    end
    return m;
  endfunction

  localparam logic [LINES-1:0] PASS_MASK = passMaskCalc();

  logic [LINES-1:0] levelQ;
  logic [LINES-1:0] maskQ;
  logic [LINES-1:0] passEnQ;
  logic [LINES-1:0] maskedLvl;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) levelQ <= '0;
    else       levelQ <= irqIn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskQ <= '0;
    end else begin
      if (strb.maskSet) maskQ <= maskQ | wdata;
      if (strb.maskClr) maskQ <= maskQ & ~wdata;
      if (strb.softSet) maskQ[0] <= 1'b1;
      if (strb.softClr) maskQ[0] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      passEnQ <= '0;
    end else begin
      if (strb.passSet) passEnQ <= passEnQ | (wdata & PASS_MASK);
      if (strb.passClr) passEnQ <= passEnQ & ~wdata;
    end
  end

  assign maskedLvl = levelQ & maskQ;

  always_comb begin
    case (rdSel)
      RD_STATUS: rdata = maskedLvl;
      RD_RAW:    rdata = levelQ;
      RD_MASK:   rdata = maskQ;
      RD_SOFT:   rdata = {{(LINES-1){1'b0}}, levelQ[0]};
      RD_PASS:   rdata = passEnQ;
      default:   rdata = '0;
    endcase
  end

  for (genvar i = 0; i < LINES; i++) begin : g_lane
    if (i == CASC_IDX) begin : g_casc
      assign irqOut[i] = |maskedLvl;
    end else if (i >= PASS_LO && i <= PASS_HI) begin : g_pass
      assign irqOut[i] = passEnQ[i] & levelQ[i];
    end else begin : g_tie
      assign irqOut[i] = 1'b0;
    end
  end

  // R2
  lvl_track_chk: assert property (@(posedge clk) disable iff (!rstN)
    rstN |=> levelQ == $past(irqIn));

  // R4
  mask_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.maskSet |=> (maskQ & $past(wdata)) == $past(wdata));

  // R5
  mask_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.maskClr |=> (maskQ & $past(wdata)) == '0);

  // R6
  soft_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.softSet |=> maskQ[0]);

  // R6
  soft_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.softClr |=> !maskQ[0]);

  // R7
  pass_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.passClr |=> (passEnQ & $past(wdata)) == '0);

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb == '0) |=> $stable(maskQ) && $stable(passEnQ));

endmodule

// File: rtl/casc_irq_ctrl.sv
module casc_irq_ctrl
  import casc_irq_pkg::*;
#(
  parameter int unsigned LINES   = 32,
  parameter int unsigned WORD_AW = 10,
  parameter int unsigned PASS_LO = 21,
  parameter int unsigned PASS_HI = 30
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [LINES-1:0]   irqIn,
  input  logic               busSel,
  input  logic               busWr,
  input  logic [WORD_AW-1:0] busAddr,
  input  logic [LINES-1:0]   busWdata,
  output logic [LINES-1:0]   busRdata,
  output logic [LINES-1:0]   irqOut
);

  wrStrobe_t strb;
  rdSel_t    rdSel;

  casc_irq_decode #(
    .WORD_AW (WORD_AW),
    .DATA_W  (LINES)
  ) u_decode (
    .busSel   (busSel),
    .busWr    (busWr),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .strb     (strb),
    .rdSel    (rdSel)
  );

  casc_irq_datapath #(
    .LINES   (LINES),
    .PASS_LO (PASS_LO),
    .PASS_HI (PASS_HI)
  ) u_datapath (
    .clk    (clk),
    .rstN   (rstN),
    .irqIn  (irqIn),
    .wdata  (busWdata),
    .strb   (strb),
    .rdSel  (rdSel),
    .rdata  (busRdata),
    .irqOut (irqOut)
  );

endmodule

// File: tb/casc_irq_ctrl_bench.sv
`timescale 1ns/1ps
module casc_irq_ctrl_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] irqIn = '0;
  logic        busSel = 1'b0;
  logic        busWr = 1'b0;
  logic [9:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [31:0] irqOut;

  int checks = 0;
  int errors = 0;

  logic [31:0] mdlLvl = '0;
  logic [31:0] mdlMask = '0;
  logic [31:0] mdlPass = '0;

  always #2.5 clk = ~clk;

  casc_irq_ctrl u_casc_irq_ctrl (
    .clk(clk), .rstN(rstN), .irqIn(irqIn), .busSel(busSel), .busWr(busWr),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata), .irqOut(irqOut)
  );

  function automatic logic [31:0] expOut(logic [31:0] lvl, logic [31:0] msk, logic [31:0] pas);
    logic [31:0] o;
    o = '0;
    for (int i = 21; i <= 30; i++) o[i] = pas[i] & lvl[i];
    o[31] = |(lvl & msk);
    return o;
  endfunction

  function automatic logic [31:0] expRead(int w, logic [31:0] lvl, logic [31:0] msk, logic [31:0] pas);
    case (w)
      0:       return lvl & msk;
      1:       return lvl;
      2:       return msk;
      4:       return {31'b0, lvl[0]};
      8:       return pas;
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic readAll(string base);
    int words [10] = '{0, 1, 2, 3, 4, 5, 8, 9, 6, 1023};
    foreach (words[k]) begin
      busAddr = 10'(words[k]);
      #0.2;
      case (words[k])
        0: chk({base, " R3 status"}, busRdata, expRead(0, mdlLvl, mdlMask, mdlPass));
        1: chk({base, " R2 raw"}, busRdata, expRead(1, mdlLvl, mdlMask, mdlPass));
        2: chk({base, " R4 mask"}, busRdata, expRead(2, mdlLvl, mdlMask, mdlPass));
        4: chk({base, " R6 soft"}, busRdata, expRead(4, mdlLvl, mdlMask, mdlPass));
        8: chk({base, " R7 pass"}, busRdata, expRead(8, mdlLvl, mdlMask, mdlPass));
        default: chk({base, " R9 unlisted read"}, busRdata, 32'h0);
      endcase
    end
  endtask

  task automatic applyModel(int w, logic [31:0] d);
    case (w)
      2: mdlMask = mdlMask | d;
      3: mdlMask = mdlMask & ~d;
      4: if (d != 0) mdlMask[0] = 1'b1;
      5: if (d != 0) mdlMask[0] = 1'b0;
      8: mdlPass = mdlPass | (d & 32'h7FE00000);
      9: mdlPass = mdlPass & ~d;
      default: ;
    endcase
  endtask

  task automatic step(bit doWr, int w, logic [31:0] d, logic [31:0] newIn);
    @(negedge clk);
    irqIn    = newIn;
    busSel   = doWr;
    busWr    = doWr;
    busAddr  = 10'(w);
    busWdata = d;
    #1;
    // R10: nothing moves before the strobe edge
    chk("R10 pre-edge output", irqOut, expOut(mdlLvl, mdlMask, mdlPass));
    @(posedge clk);
    #1;
    busSel = 1'b0;
    busWr  = 1'b0;
    mdlLvl = newIn;
    if (doWr) applyModel(w, d);
    chk("R3 R8 outputs", irqOut, expOut(mdlLvl, mdlMask, mdlPass));
    readAll("step");
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : stim
    void'($urandom(32'd4242));
    irqIn = 32'hFFFF_FFFF;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    chk("R1 reset outputs", irqOut, 32'h0);
    busAddr = 10'd1; #0.2; chk("R1 reset raw", busRdata, 32'h0);
    busAddr = 10'd2; #0.2; chk("R1 reset mask", busRdata, 32'h0);
    busAddr = 10'd8; #0.2; chk("R1 reset pass", busRdata, 32'h0);
    irqIn = '0;
    @(negedge clk);
    rstN = 1'b1;
    step(0, 0, 0, 32'h0);

    // R7: only bits 21..30 can be set
    step(1, 8, 32'hFFFF_FFFF, 32'h0);
    // R8: pass-through follows level with mask clear
    step(0, 0, 0, 32'hC060_0001);
    // R6: zero write has no effect, nonzero sets bit 0
    step(1, 4, 32'h0, 32'hC060_0001);
    step(1, 4, 32'h0000_0100, 32'hC060_0001);
    step(1, 5, 32'h0, 32'hC060_0001);
    step(1, 5, 32'h8000_0000, 32'hC060_0001);
    // R4/R5: set and clear mask
    step(1, 2, 32'h8000_0000, 32'hC060_0001);
    step(1, 3, 32'hFFFF_FFFF, 32'hC060_0001);
    // R9: ignored writes with lines high and mask clear
    step(1, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    step(1, 1, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    step(1, 6, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    step(1, 1023, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    // R7: clear pass bits
    step(1, 9, 32'h2000_0000, 32'hFFFF_FFFF);
    step(1, 9, 32'hFFFF_FFFF, 32'hFFFF_FFFF);

    for (int n = 0; n < 600; n++) begin
      int r;
      int w;
      logic [31:0] d;
      logic [31:0] ni;
      r = int'($urandom % 13);
      case (r)
        10: w = 1023;
        11: w = 7;
        12: w = 6;
        default: w = r;
      endcase
      d  = ($urandom % 4 == 0) ? 32'h0 : $urandom;
      ni = ($urandom % 2 == 0) ? mdlLvl : $urandom;
      step(($urandom % 3) != 0, w, d, ni);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule